// File: doc/BRIEF.md
# SPI controller interrupt and register unit

This block is the register front end and interrupt collector of a SPI master with up to four channels. A 32-bit memory-mapped bus reaches a set of module-wide registers and one register bank per channel. The channel sequencers live outside the block. They report "transmit buffer empty" and "receive buffer full" events on input pins. They take their configuration, enable and transmit word from output ports, and they supply their own status and received word for read-back.

Each event sets a latched interrupt status bit. Software clears a status bit by writing a 1 to it. A single interrupt line is the OR of the status bits that are enabled. A system-test mode lets software force every implemented status bit high and freeze the clearing path, so that the interrupt wiring can be exercised without real traffic. A soft-reset bit returns the module registers to their initial state.

Bus reads return data in the same cycle as the read strobe. Writes take effect at the clock edge that samples the write strobe.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the registers read as follows: 0x00 reads 0x91; 0x14 reads 1; 0x10, 0x18, 0x1C, 0x20 and 0x24 read 0; 0x28 reads 4. Each channel's configuration word reads 0x060000 and its control word reads 0.
- R2: Channel n owns five words starting at 0x2C + 0x14·n, in this order: configuration, status, control, transmit, receive. The status word and the receive word return `ch_stat_in` and `ch_rx_in` for that channel. Writes to the status word and the receive word change nothing and raise no error. In the cycle of the access, a write to the transmit word pulses `ch_tx_wr[n]` and a read of the receive word pulses `ch_rx_rd[n]`.
- R3: `tx_empty_evt[n]` sets status bit 4·n and `rx_full_evt[n]` sets status bit 4·n+2 (status word at 0x18). The enable word at 0x1C keeps only the bits in 0x1777F.
- R4: `irq` is high exactly when the status word AND the enable word is nonzero. It follows each register update from the next clock edge.
- R5: Writing 0x18 clears each status bit that is written as 1 and leaves the other status bits as they were.
- R6: A write to 0x18 has no effect while module-control (0x28) bit 3 and system-test (0x24) bit 11 are both set.
- R7: A write to 0x24 with bit 11 set, while module-control bit 3 is already set, sets every status bit in 0x1777F.
- R8: A write to 0x28 with bit 3 set, while system-test bit 11 is already set, sets every status bit in 0x1777F.
- R9: A write to 0x10 with bit 1 set does the following: status, enable, system test and wakeup return to 0; module control returns to 4; every channel bank returns to its reset values; 0x10 keeps the written value AND 0x31D. Without bit 1 set, 0x10 still keeps the value AND 0x31D.
- R10: The stored widths are 4 bits for module control, 12 bits for system test, 1 bit for wakeup, 23 bits for channel configuration and 1 bit for channel control. The transmit word keeps all 32 bits. The bits above each width read as 0.
- R11: An access to any other offset, or to an offset that is not a multiple of 4, has these results: a read returns 0, a write changes nothing, and `bus_err` is high for exactly the one cycle after the access.
- R12: When a channel event and a bus clear hit the same status bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| bus_err | output | 1 | One-cycle pulse after an access to an undefined offset |
| tx_empty_evt | input | NCH | Per-channel transmit-empty event |
| rx_full_evt | input | NCH | Per-channel receive-full event |
| ch_stat_in | input | 32·NCH | Per-channel status words from the sequencers |
| ch_rx_in | input | 32·NCH | Per-channel received words |
| ch_conf | output | 23·NCH | Per-channel configuration |
| ch_en | output | NCH | Per-channel enable |
| ch_tx | output | 32·NCH | Per-channel transmit word |
| ch_tx_wr | output | NCH | Transmit-word write pulse |
| ch_rx_rd | output | NCH | Receive-word read pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the test-mode interplay. It forces through both entry orders, and then tries to clear while the lock holds. A design that checked the new register value instead of the held one would force on the wrong write, or it would let the clear through. It collides an event with a clear of the same bit, where a clear-first design would lose the event. It probes misaligned addresses and the word just past the last bank; a loose decoder would alias those accesses onto real registers. A reference model compares `irq` and `bus_err` on every clock, so a stuck or stretched error pulse is caught.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   localparam logic [7:0] OFS_REV       = 8'h00;
   localparam logic [7:0] OFS_SYSCFG    = 8'h10;
   localparam logic [7:0] OFS_SYSSTAT   = 8'h14;
   localparam logic [7:0] OFS_IRQST     = 8'h18;
   localparam logic [7:0] OFS_IRQEN     = 8'h1C;
   localparam logic [7:0] OFS_WKEN      = 8'h20;
   localparam logic [7:0] OFS_SYST      = 8'h24;
   localparam logic [7:0] OFS_MODCTL    = 8'h28;
   localparam logic [7:0] OFS_CH_BASE   = 8'h2C;
   localparam logic [7:0] OFS_CH_STRIDE = 8'h14;

   localparam logic [31:0] REV_CODE    = 32'h91;
   localparam logic [31:0] SYSCFG_KEEP = 32'h31D;

   localparam int MODCTL_W = 4;
   localparam int SYST_W   = 12;
   localparam int CHCONF_W = 23;

   localparam logic [MODCTL_W-1:0] MODCTL_RST = 4'h4;
   localparam logic [CHCONF_W-1:0] CHCONF_RST = 23'h060000;

   localparam int TEST_MODE_BIT  = 3;
   localparam int SYST_FORCE_BIT = 11;
   localparam int SOFTRST_BIT    = 1;

   typedef enum logic [3:0] {
      GR_NONE, GR_REV, GR_SYSCFG, GR_SYSSTAT, GR_IRQST,
      GR_IRQEN, GR_WKEN, GR_SYST, GR_MODCTL
   } greg_e;

   // The field order inside a channel bank follows the word order on the bus.
   typedef enum logic [2:0] {
      CF_CONF = 3'd0, CF_STAT = 3'd1, CF_CTRL = 3'd2,
      CF_TX   = 3'd3, CF_RX   = 3'd4, CF_NONE = 3'd7
   } chf_e;

   typedef struct packed {
      greg_e      greg;
      logic       ch_hit;
      logic [1:0] ch_idx;
      chf_e       field;
   } dec_t;

   // Implemented status bits: four in the first nibble, three in each
   // following nibble, and one bit above the last channel.
   function automatic logic [31:0] impl_mask(input int nch);
      logic [31:0] m;
      m = '0;
      for (int n = 0; n < nch; n++)
         m = m | ((n == 0 ? 32'hF : 32'h7) << (4 * n));
      m = m | (32'h1 << (4 * nch));
      return m;
   endfunction

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
   import spi_irq_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 8
) (
   input  logic [AW-1:0] addr,
   output dec_t          dec,
   output logic          hit
);

   localparam logic [31:0] STRIDE = 32'(OFS_CH_STRIDE);
   localparam logic [31:0] BASE   = 32'(OFS_CH_BASE);

   logic [31:0] a32;
   logic [31:0] lo;
   logic [31:0] rel;

   assign a32 = 32'(addr);

   always_comb begin
      dec = '{greg: GR_NONE, ch_hit: 1'b0, ch_idx: 2'd0, field: CF_NONE};
      lo  = '0;
      rel = '0;
      if (a32[1:0] == 2'b00) begin
         case (a32)
            32'(OFS_REV):     dec.greg = GR_REV;
            32'(OFS_SYSCFG):  dec.greg = GR_SYSCFG;
            32'(OFS_SYSSTAT): dec.greg = GR_SYSSTAT;
            32'(OFS_IRQST):   dec.greg = GR_IRQST;
            32'(OFS_IRQEN):   dec.greg = GR_IRQEN;
            32'(OFS_WKEN):    dec.greg = GR_WKEN;
            32'(OFS_SYST):    dec.greg = GR_SYST;
            32'(OFS_MODCTL):  dec.greg = GR_MODCTL;
            default:          dec.greg = GR_NONE;
         endcase
         for (int n = 0; n < NCH; n++) begin
            lo = BASE + STRIDE * 32'(n);
            if (a32 >= lo && a32 < lo + STRIDE) begin
               rel        = a32 - lo;
               dec.ch_hit = 1'b1;
               dec.ch_idx = 2'(n);
               dec.field  = chf_e'(rel[4:2]);
            end
         end
      end
   end

   assign hit = (dec.greg != GR_NONE) || dec.ch_hit;

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
   parameter int               IRQW = 17,
   parameter logic [IRQW-1:0]  MASK = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            soft_rst,
   input  logic [IRQW-1:0] set_vec,
   input  logic            clr_wr,
   input  logic            clr_lock,
   input  logic [IRQW-1:0] clr_vec,
   input  logic            force_all,
   input  logic            en_wr,
   input  logic [IRQW-1:0] en_data,
   output logic [IRQW-1:0] st,
   output logic [IRQW-1:0] en,
   output logic            irq
);

   logic [IRQW-1:0] clr_eff;
   logic [IRQW-1:0] st_n;

   // A set arriving in the same cycle as a clear wins, because it is ORed after the clear.
   always_comb begin
      clr_eff = (clr_wr && !clr_lock) ? clr_vec : '0;
      st_n    = ((st & ~clr_eff) | set_vec | (force_all ? MASK : '0)) & MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
         en <= '0;
      end else if (soft_rst) begin
         st <= '0;
         en <= '0;
      end else begin
         st <= st_n;
         if (en_wr) en <= en_data & MASK;
      end
   end

   always_comb irq = |(st & en);

endmodule

// File: rtl/spi_irq_chbank.sv
module spi_irq_chbank
   import spi_irq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                soft_rst,
   input  logic                wr_conf,
   input  logic                wr_ctrl,
   input  logic                wr_tx,
   input  logic [31:0]         wdata,
   output logic [CHCONF_W-1:0] conf,
   output logic                en,
   output logic [31:0]         tx
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conf <= CHCONF_RST;
         en   <= 1'b0;
         tx   <= '0;
      end else if (soft_rst) begin
         conf <= CHCONF_RST;
         en   <= 1'b0;
         tx   <= '0;
      end else begin
         if (wr_conf) conf <= wdata[CHCONF_W-1:0];
         if (wr_ctrl) en   <= wdata[0];
         if (wr_tx)   tx   <= wdata;
      end
   end

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
   import spi_irq_pkg::*;
#(
   parameter int NCH = 4,
   parameter int AW  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [AW-1:0]          bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   output logic                   bus_err,
   input  logic [NCH-1:0]         tx_empty_evt,
   input  logic [NCH-1:0]         rx_full_evt,
   input  logic [NCH*32-1:0]      ch_stat_in,
   input  logic [NCH*32-1:0]      ch_rx_in,
   output logic [NCH*CHCONF_W-1:0] ch_conf,
   output logic [NCH-1:0]         ch_en,
   output logic [NCH*32-1:0]      ch_tx,
   output logic [NCH-1:0]         ch_tx_wr,
   output logic [NCH-1:0]         ch_rx_rd,
   output logic                   irq
);

   localparam int              IRQW     = 4 * NCH + 1;
   localparam logic [IRQW-1:0] IRQ_MASK = IRQW'(impl_mask(NCH));

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("spi_irq_regs: NCH must lie in 1..4");
   end
   if (AW < 7) begin : g_bad_aw
      $error("spi_irq_regs: AW too narrow for the channel banks");
   end

   dec_t dec;
   logic dec_hit;

   spi_irq_decode #(.NCH(NCH), .AW(AW)) u_dec (
      .addr (bus_addr),
      .dec  (dec),
      .hit  (dec_hit)
   );

   logic [31:0]         sysconf_q;
   logic [SYST_W-1:0]   syst_q;
   logic [MODCTL_W-1:0] modctl_q;
   logic                wken_q;

   logic soft_rst, force_all, clr_lock;
   logic wr_irqst, wr_irqen;

   always_comb begin
      soft_rst  = bus_wr && dec.greg == GR_SYSCFG && bus_wdata[SOFTRST_BIT];
      clr_lock  = modctl_q[TEST_MODE_BIT] && syst_q[SYST_FORCE_BIT];
      force_all = (bus_wr && dec.greg == GR_SYST && bus_wdata[SYST_FORCE_BIT]
                   && modctl_q[TEST_MODE_BIT])
               || (bus_wr && dec.greg == GR_MODCTL && bus_wdata[TEST_MODE_BIT]
                   && syst_q[SYST_FORCE_BIT]);
      wr_irqst  = bus_wr && dec.greg == GR_IRQST;
      wr_irqen  = bus_wr && dec.greg == GR_IRQEN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sysconf_q <= '0;
         syst_q    <= '0;
         modctl_q  <= MODCTL_RST;
         wken_q    <= 1'b0;
      end else if (soft_rst) begin
         sysconf_q <= bus_wdata & SYSCFG_KEEP;
         syst_q    <= '0;
         modctl_q  <= MODCTL_RST;
         wken_q    <= 1'b0;
      end else if (bus_wr) begin
         case (dec.greg)
            GR_SYSCFG: sysconf_q <= bus_wdata & SYSCFG_KEEP;
            GR_WKEN:   wken_q    <= bus_wdata[0];
            GR_SYST:   syst_q    <= bus_wdata[SYST_W-1:0];
            GR_MODCTL: modctl_q  <= bus_wdata[MODCTL_W-1:0];
            default:   ;
         endcase
      end
   end

   logic [IRQW-1:0] set_vec;
   logic [IRQW-1:0] irq_st;
   logic [IRQW-1:0] irq_en;

   always_comb begin
      set_vec = '0;
      for (int n = 0; n < NCH; n++) begin
         set_vec[4*n]     = tx_empty_evt[n];
         set_vec[4*n + 2] = rx_full_evt[n];
      end
   end

   spi_irq_status #(.IRQW(IRQW), .MASK(IRQ_MASK)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .set_vec   (set_vec),
      .clr_wr    (wr_irqst),
      .clr_lock  (clr_lock),
      .clr_vec   (bus_wdata[IRQW-1:0]),
      .force_all (force_all),
      .en_wr     (wr_irqen),
      .en_data   (bus_wdata[IRQW-1:0]),
      .st        (irq_st),
      .en        (irq_en),
      .irq       (irq)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic sel;
      assign sel = dec.ch_hit && dec.ch_idx == 2'(n);

      spi_irq_chbank u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .wr_conf  (bus_wr && sel && dec.field == CF_CONF),
         .wr_ctrl  (bus_wr && sel && dec.field == CF_CTRL),
         .wr_tx    (bus_wr && sel && dec.field == CF_TX),
         .wdata    (bus_wdata),
         .conf     (ch_conf[n*CHCONF_W +: CHCONF_W]),
         .en       (ch_en[n]),
         .tx       (ch_tx[n*32 +: 32])
      );

      assign ch_tx_wr[n] = bus_wr && sel && dec.field == CF_TX;
      assign ch_rx_rd[n] = bus_rd && sel && dec.field == CF_RX;
   end

   int unsigned ci;
   logic [31:0] rd_val;

   always_comb begin
      ci     = 32'(dec.ch_idx);
      rd_val = '0;
      case (dec.greg)
         GR_REV:     rd_val = REV_CODE;
         GR_SYSCFG:  rd_val = sysconf_q;
         GR_SYSSTAT: rd_val = 32'h1;
         GR_IRQST:   rd_val = 32'(irq_st);
         GR_IRQEN:   rd_val = 32'(irq_en);
         GR_WKEN:    rd_val = 32'(wken_q);
         GR_SYST:    rd_val = 32'(syst_q);
         GR_MODCTL:  rd_val = 32'(modctl_q);
         default:    rd_val = '0;
      endcase
      if (dec.ch_hit && ci < NCH) begin
         case (dec.field)
            CF_CONF: rd_val = 32'(ch_conf[ci*CHCONF_W +: CHCONF_W]);
            CF_STAT: rd_val = ch_stat_in[ci*32 +: 32];
            CF_CTRL: rd_val = 32'(ch_en[ci]);
            CF_TX:   rd_val = ch_tx[ci*32 +: 32];
            CF_RX:   rd_val = ch_rx_in[ci*32 +: 32];
            default: rd_val = '0;
         endcase
      end
      bus_rdata = (bus_rd && dec_hit) ? rd_val : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_err <= 1'b0;
      else        bus_err <= (bus_wr || bus_rd) && !dec_hit;
   end

endmodule

// File: rtl/spi_irq_chk.sv
module spi_irq_chk
   import spi_irq_pkg::*;
#(
   parameter int              AW   = 8,
   parameter int              IRQW = 17,
   parameter logic [IRQW-1:0] MASK = '1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic                bus_rd,
   input logic [AW-1:0]       bus_addr,
   input logic [31:0]         bus_wdata,
   input logic                hit,
   input logic                bus_err,
   input logic [IRQW-1:0]     st,
   input logic [IRQW-1:0]     en,
   input logic [MODCTL_W-1:0] modctl,
   input logic [SYST_W-1:0]   syst,
   input logic                tx_evt0
);

   logic is_st, is_syst, is_mod, is_cfg, srst;
   always_comb begin
      is_st   = bus_wr && 32'(bus_addr) == 32'(OFS_IRQST);
      is_syst = bus_wr && 32'(bus_addr) == 32'(OFS_SYST);
      is_mod  = bus_wr && 32'(bus_addr) == 32'(OFS_MODCTL);
      is_cfg  = bus_wr && 32'(bus_addr) == 32'(OFS_SYSCFG);
      srst    = is_cfg && bus_wdata[SOFTRST_BIT];
   end

   a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_evt0 && !srst) |=> st[0]);

   a_r6_clear_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (is_st && modctl[TEST_MODE_BIT] && syst[SYST_FORCE_BIT])
      |=> ((st & $past(st)) == $past(st)));

   a_r7_force_by_syst: assert property (@(posedge clk) disable iff (!rst_n)
      (is_syst && bus_wdata[SYST_FORCE_BIT] && modctl[TEST_MODE_BIT]) |=> (st == MASK));

   a_r8_force_by_mod: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mod && bus_wdata[TEST_MODE_BIT] && syst[SYST_FORCE_BIT]) |=> (st == MASK));

   a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (st == '0 && en == '0 && modctl == MODCTL_RST));

   a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past((bus_wr || bus_rd) && !hit));

   a_r11_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_wr || bus_rd) && !hit) |=> bus_err);

   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_evt0 && is_st && bus_wdata[0]) |=> st[0]);

endmodule

bind spi_irq_regs spi_irq_chk #(.AW(AW), .IRQW(IRQW), .MASK(IRQ_MASK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .hit       (dec_hit),
   .bus_err   (bus_err),
   .st        (irq_st),
   .en        (irq_en),
   .modctl    (modctl_q),
   .syst      (syst_q),
   .tx_evt0   (tx_empty_evt[0])
);

// File: tb/spi_irq_regs_bench.sv
`timescale 1ns/1ps
module spi_irq_regs_bench;

   localparam int NCH = 4;
   localparam logic [31:0] MSK = 32'h1777F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic bus_err;
   logic [NCH-1:0] tx_empty_evt = '0, rx_full_evt = '0;
   logic [NCH*32-1:0] ch_stat_in, ch_rx_in;
   logic [NCH*23-1:0] ch_conf;
   logic [NCH-1:0] ch_en, ch_tx_wr, ch_rx_rd;
   logic [NCH*32-1:0] ch_tx;
   logic irq;

   always #5 clk = ~clk;

   spi_irq_regs #(.NCH(NCH), .AW(8)) u_spi_irq_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_err(bus_err), .tx_empty_evt(tx_empty_evt), .rx_full_evt(rx_full_evt),
      .ch_stat_in(ch_stat_in), .ch_rx_in(ch_rx_in), .ch_conf(ch_conf),
      .ch_en(ch_en), .ch_tx(ch_tx), .ch_tx_wr(ch_tx_wr), .ch_rx_rd(ch_rx_rd),
      .irq(irq)
   );

   int checks = 0;
   int failures = 0;
   bit done = 0;

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Behavioural reference model
   logic [31:0] m_cfg, m_syst, m_mod, m_wk, m_st, m_en;
   logic [31:0] m_conf [NCH];
   logic [31:0] m_ctl  [NCH];
   logic [31:0] m_tx   [NCH];
   logic m_err;

   function automatic bit defined(input int a);
      if (a % 4 != 0) return 0;
      if (a == 0 || (a >= 'h10 && a <= 'h28)) return 1;
      return (a >= 'h2C && a < 'h2C + 'h14 * NCH);
   endfunction

   task automatic m_reset();
      m_cfg = 0; m_syst = 0; m_mod = 4; m_wk = 0; m_st = 0; m_en = 0; m_err = 0;
      for (int i = 0; i < NCH; i++) begin
         m_conf[i] = 32'h060000; m_ctl[i] = 0; m_tx[i] = 0;
      end
   endtask

   task automatic m_step();
      int a;
      logic [31:0] wd, nst, old_mod, old_syst;
      bit def, srst;
      a = int'(bus_addr); wd = bus_wdata; def = defined(a);
      old_mod = m_mod; old_syst = m_syst; nst = m_st; srst = 0;
      if (bus_wr && def && a == 'h18 && !(old_mod[3] && old_syst[11])) nst = nst & ~wd;
      for (int n = 0; n < NCH; n++) begin
         if (tx_empty_evt[n]) nst = nst | (32'h1 << (4 * n));
         if (rx_full_evt[n])  nst = nst | (32'h1 << (4 * n + 2));
      end
      if (bus_wr && def) begin
         if (a == 'h24) begin
            if (old_mod[3] && wd[11]) nst = nst | MSK;
            m_syst = wd & 32'hFFF;
         end else if (a == 'h28) begin
            if (wd[3] && old_syst[11]) nst = nst | MSK;
            m_mod = wd & 32'hF;
         end else if (a == 'h1C) m_en = wd & MSK;
         else if (a == 'h20) m_wk = wd & 1;
         else if (a == 'h10) begin
            srst = wd[1];
            m_cfg = wd & 32'h31D;
         end else if (a >= 'h2C) begin
            int ch, f;
            ch = (a - 'h2C) / 'h14;
            f  = ((a - 'h2C) % 'h14) / 4;
            if (f == 0) m_conf[ch] = wd & 32'h7FFFFF;
            else if (f == 2) m_ctl[ch] = wd & 1;
            else if (f == 3) m_tx[ch] = wd;
         end
      end
      m_st = nst & MSK;
      if (srst) begin
         logic [31:0] keep;
         keep = m_cfg;
         m_reset();
         m_cfg = keep;
      end
      m_err = (bus_wr || bus_rd) && !def;
   endtask

   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else m_step();
   end

   // Compare irq and bus_err against the model on every clock (R4, R11)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(32'(irq), 32'(((m_st & m_en) != 0)), "R4 model irq");
         chk(32'(bus_err), 32'(m_err), "R11 model bus_err");
      end
   end

   task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                      input logic [31:0] d, input logic [3:0] te, input logic [3:0] re);
      @(negedge clk); #1;
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      tx_empty_evt = te; rx_full_evt = re;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1, 0, a, d, 4'h0, 4'h0);
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      cyc(0, 1, a, 0, 4'h0, 4'h0);
      #1 chk(bus_rdata, exp, tag);
   endtask

   task automatic idle_chk_err(input logic exp, input string tag);
      cyc(0, 0, 8'h00, 0, 4'h0, 4'h0);
      chk(32'(bus_err), 32'(exp), tag);
   endtask

   initial begin
      for (int n = 0; n < NCH; n++) begin
         ch_stat_in[n*32 +: 32] = 32'h0000_0100 + n;
         ch_rx_in[n*32 +: 32]   = 32'hA5A5_0000 + n;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd_chk(8'h00, 32'h91, "R1 revision");
      rd_chk(8'h14, 32'h1, "R1 sysstatus");
      rd_chk(8'h10, 32'h0, "R1 sysconfig");
      rd_chk(8'h18, 32'h0, "R1 irq status");
      rd_chk(8'h1C, 32'h0, "R1 irq enable");
      rd_chk(8'h20, 32'h0, "R1 wakeup");
      rd_chk(8'h24, 32'h0, "R1 systest");
      rd_chk(8'h28, 32'h4, "R1 modctl");
      rd_chk(8'h2C, 32'h060000, "R1 ch0 conf");
      rd_chk(8'h70, 32'h0, "R1 ch3 ctrl");
      chk(32'(irq), 0, "R1 irq low");

      // R10 field widths
      wr(8'h28, 32'hFFFF_FFF7);
      rd_chk(8'h28, 32'h7, "R10 modctl width");
      wr(8'h28, 32'h4);
      wr(8'h24, 32'hFFFF_F7FF);
      rd_chk(8'h24, 32'h7FF, "R10 systest width");
      wr(8'h24, 32'h0);
      wr(8'h20, 32'hFFFF_FFFF);
      rd_chk(8'h20, 32'h1, "R10 wakeup width");
      wr(8'h40, 32'hFFFF_FFFF);
      rd_chk(8'h40, 32'h7F_FFFF, "R10 ch1 conf width");
      chk(32'(ch_conf[23 +: 23]), 32'h7F_FFFF, "R10 ch1 conf port");
      wr(8'h70, 32'hFFFF_FFFF);
      rd_chk(8'h70, 32'h1, "R10 ch3 ctrl width");
      chk(32'(ch_en), 32'h8, "R10 ch_en port");

      // R2 channel banks
      wr(8'h60, 32'hCAFE_0002);
      #1 chk(32'(ch_tx_wr), 32'h4, "R2 tx write pulse");
      rd_chk(8'h60, 32'hCAFE_0002, "R2 ch2 tx readback");
      chk(ch_tx[64 +: 32], 32'hCAFE_0002, "R2 ch2 tx port");
      rd_chk(8'h44, 32'h0000_0101, "R2 ch1 status input");
      rd_chk(8'h78, 32'hA5A5_0003, "R2 ch3 rx input");
      chk(32'(ch_rx_rd), 32'h8, "R2 rx read pulse");
      wr(8'h44, 32'hFFFF_FFFF);
      idle_chk_err(1'b0, "R2 no error on read-only write");
      rd_chk(8'h44, 32'h0000_0101, "R2 status write ignored");
      rd_chk(8'h2C, 32'h060000, "R2 ch0 conf untouched");

      // R9 sysconfig mask without reset
      wr(8'h10, 32'hFFFF_FFFD);
      rd_chk(8'h10, 32'h31D, "R9 sysconfig mask");

      // R3 events and enable mask
      wr(8'h1C, 32'hFFFF_FFFF);
      rd_chk(8'h1C, 32'h1777F, "R3 enable mask");
      wr(8'h1C, 32'h0);
      cyc(0, 0, 8'h00, 0, 4'b0001, 4'b0100);
      rd_chk(8'h18, 32'h401, "R3 tx0 and rx2 events");
      chk(32'(irq), 0, "R4 irq masked");
      cyc(0, 0, 8'h00, 0, 4'b1000, 4'b0000);
      rd_chk(8'h18, 32'h1401, "R3 tx3 event");
      wr(8'h1C, 32'h400);
      idle_chk_err(1'b0, "R4 idle");
      chk(32'(irq), 1, "R4 irq raised by enable");

      // R5 write one to clear
      wr(8'h18, 32'h400);
      rd_chk(8'h18, 32'h1001, "R5 selective clear");
      chk(32'(irq), 0, "R5 irq dropped");

      // R12 set wins
      cyc(1, 0, 8'h18, 32'h1, 4'b0001, 4'b0000);
      rd_chk(8'h18, 32'h1001, "R12 set beats clear");
      wr(8'h18, 32'hFFFF_FFFF);
      rd_chk(8'h18, 32'h0, "R5 clear all");

      // R7 force through systest write
      wr(8'h28, 32'h8);
      rd_chk(8'h18, 32'h0, "R7 test mode alone");
      wr(8'h24, 32'h800);
      rd_chk(8'h18, 32'h1777F, "R7 force all");
      chk(32'(irq), 1, "R7 irq forced");

      // R6 clear locked
      wr(8'h18, 32'hFFFF_FFFF);
      rd_chk(8'h18, 32'h1777F, "R6 clear ignored");
      wr(8'h24, 32'h0);
      wr(8'h18, 32'hFFFF_FFFF);
      rd_chk(8'h18, 32'h0, "R6 clear after unlock");

      // R8 force through module control write
      wr(8'h28, 32'h0);
      wr(8'h24, 32'h800);
      rd_chk(8'h18, 32'h0, "R8 no force without test mode");
      wr(8'h28, 32'h8);
      rd_chk(8'h18, 32'h1777F, "R8 force all");

      // R11 undefined offsets
      rd_chk(8'h04, 32'h0, "R11 hole read zero");
      idle_chk_err(1'b1, "R11 error pulse");
      idle_chk_err(1'b0, "R11 pulse ends");
      rd_chk(8'h2E, 32'h0, "R11 misaligned read zero");
      idle_chk_err(1'b1, "R11 misaligned error");
      wr(8'h7C, 32'hFFFF_FFFF);
      idle_chk_err(1'b1, "R11 past-bank error");
      rd_chk(8'h74, 32'h0, "R11 past-bank write ignored");
      wr(8'h29, 32'h0);
      idle_chk_err(1'b1, "R11 misaligned write error");
      rd_chk(8'h28, 32'h8, "R11 misaligned write ignored");

      // R9 soft reset
      wr(8'h10, 32'h13);
      rd_chk(8'h10, 32'h11, "R9 sysconfig kept");
      rd_chk(8'h18, 32'h0, "R9 status cleared");
      rd_chk(8'h1C, 32'h0, "R9 enable cleared");
      rd_chk(8'h28, 32'h4, "R9 modctl reset");
      rd_chk(8'h24, 32'h0, "R9 systest reset");
      rd_chk(8'h40, 32'h060000, "R9 ch1 conf reset");
      chk(32'(irq), 0, "R9 irq low");

      cyc(0, 0, 8'h00, 0, 4'h0, 4'h0);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(100000 * 10);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule